// File: doc/BRIEF.md
# Network Controller Power-State and Wake Controller

This block manages the device power state of a network controller and turns link recovery into a wake request. It runs on an auxiliary clock and reset that stay alive when the host bus loses power. As a result, the wake context survives a host bus reset, a power-good drop and a full loss of bus power. Software selects the power state and sets two enable bits through a small register write port. The block reports a PME wake request, a link-monitor indication, a link-keep indication, an "ignore bus" qualifier and a reinitialise pulse for the main datapath.

While the host bus is held in reset or power-good is low, the block disregards register writes. It also tells the rest of the device to disregard the bus. When both conditions clear, it pulses a reinitialise output for `PULSE_LEN` cycles and leaves all wake context untouched.

In D2, the block enters a low-power link-monitor substate when the link is down and the low-power enable is set. D3 behaves the same way while PME is enabled. A link transition from invalid to valid then raises a wake event. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `lan_pm_wake_ctrl`

## Requirements
- R1: Holding `bus_rst_n` low changes none of the following: the PME enable, the low-power enable, the PME status or the power state. `pme_req` keeps its value through the bus reset and after its release.
- R2: `ignore_bus` is high whenever `bus_rst_n` is low or `pwr_good` is low. Register writes made while it is high have no effect.
- R3: When `ignore_bus` falls, `reinit` goes high one clock edge later and stays high for exactly `PULSE_LEN` cycles.
- R4: With the power state at D2 (code 2'b10), the low-power enable set and the synchronised link down, `link_mon` goes high on the next clock edge. Counted from a power-state write, that is two edges. Counted from the link input falling, it is three edges.
- R5: In the link-monitor substate, a link change from invalid to valid does two things three edges after the input rises: it clears `link_mon` and, when PME is enabled, it sets the PME status so that `pme_req` goes high.
- R6: D3 (code 2'b11) with PME enabled enters the link-monitor substate and wakes exactly as D2 does.
- R7: In D3 with PME disabled, `link_keep` is low, `link_mon` stays low and no wake event occurs.
- R8: The PME status is sticky and can be set only by a wake event while PME is enabled. Writing 1 to bit 0 at address 2 clears it. `pme_req` is the status ANDed with the PME enable.
- R9: Writing D0 (code 2'b00) to the power state clears `link_mon` two edges after the write. A later link recovery then raises no wake.
- R10: After the auxiliary reset, the power state is D0, both enables and the PME status are clear, `link_mon`, `pme_req` and `reinit` are low, and `link_keep` is high.
- R11: Register map. Address 0 holds the power state in data bits [1:0]. Address 1 holds the PME enable in bit 0 and the low-power enable in bit 1. Address 2 is the status register, where writing 1 to bit 0 clears. A write takes effect on the edge that samples `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aux | input | 1 | Auxiliary-domain clock |
| rst_aux_n | input | 1 | Auxiliary-domain reset, active low |
| bus_rst_n | input | 1 | Host bus reset, active low |
| pwr_good | input | 1 | Host power-good |
| link_ok_async | input | 1 | Asynchronous link-valid indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| ignore_bus | output | 1 | Host bus inputs must be disregarded |
| reinit | output | 1 | Reinitialise pulse for the bus configuration, MAC and memory structures |
| link_mon | output | 1 | Low-power link-monitor substate active |
| link_keep | output | 1 | Link must be kept up |
| pme_req | output | 1 | PME wake request |

## Verification
Each result has a fixed due cycle, counted in clock edges from the cycle in which the bench drives the stimulus:
- `ignore_bus` and `link_keep` follow within the same cycle.
- A register write shows up after one edge.
- `link_mon` entry after a power-state write takes two edges.
- Anything that depends on a link edge takes three edges, because the link passes through two synchroniser stages and an edge detector.
- The reinitialise pulse starts after one edge and lasts `PULSE_LEN` cycles.

When the bench drives a stimulus, its driver records the due cycle of every consequence it expects. It pushes those items into a queue. A monitor compares each item on the falling edge of exactly that cycle. Items on both sides of a transition are checked, so an answer that arrives one cycle early or late fails.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  localparam int unsigned REG_PSTATE = 0;
  localparam int unsigned REG_CTRL   = 1;
  localparam int unsigned REG_STATUS = 2;
endpackage

// File: rtl/lpw_link_sync.sv
module lpw_link_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_async,
  output logic link_s,
  output logic link_rise
);
  logic [STAGES-1:0] chain;
  logic              link_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= link_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_d <= 1'b0;
    else        link_d <= chain[STAGES-1];
  end

  assign link_s    = chain[STAGES-1];
  assign link_rise = chain[STAGES-1] & ~link_d;
endmodule

// File: rtl/lpw_bus_guard.sv
module lpw_bus_guard #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst_n,
  input  logic pwr_good,
  output logic ignore_bus,
  output logic reinit
);
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

  logic             ign_d;
  logic [CNT_W-1:0] cnt;

  assign ignore_bus = ~bus_rst_n | ~pwr_good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ign_d <= 1'b1;
      cnt   <= '0;
    end else begin
      ign_d <= ignore_bus;
      if (ignore_bus)
        cnt <= '0;
      else if (ign_d)
        cnt <= CNT_W'(PULSE_LEN);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign reinit = (cnt != '0);
endmodule

// File: rtl/lpw_wake_core.sv
module lpw_wake_core
  import lpw_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              link_s,
  input  logic              link_rise,
  output pstate_e           pstate,
  output logic              pme_en,
  output logic              lp_en,
  output logic              pme_sts,
  output logic              link_mon,
  output logic              link_keep,
  output logic              pme_req
);
  logic wr_ps, wr_ctrl, wr_sts;
  logic sleep_ok, enter_ok, leave, wake, mon_n;

  assign wr_ps   = wr_ok && (wr_addr == ADDR_W'(REG_PSTATE));
  assign wr_ctrl = wr_ok && (wr_addr == ADDR_W'(REG_CTRL));
  assign wr_sts  = wr_ok && (wr_addr == ADDR_W'(REG_STATUS));

  // D2 always may sleep on link loss; D3 only while wake is armed
  assign sleep_ok = (pstate == PS_D2) || ((pstate == PS_D3) && pme_en);
  assign enter_ok = sleep_ok && lp_en && !link_s;
  assign leave    = link_rise || (pstate == PS_D0) ||
                    ((pstate == PS_D3) && !pme_en);
  assign wake     = link_mon && link_rise;

  always_comb begin
    mon_n = link_mon;
    if (!link_mon && enter_ok)
      mon_n = 1'b1;
    else if (link_mon && leave)
      mon_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate   <= PS_D0;
      pme_en   <= 1'b0;
      lp_en    <= 1'b0;
      pme_sts  <= 1'b0;
      link_mon <= 1'b0;
    end else begin
      if (wr_ps)
        pstate <= pstate_e'(wr_data[1:0]);
      if (wr_ctrl) begin
        pme_en <= wr_data[0];
        lp_en  <= wr_data[1];
      end
      link_mon <= mon_n;
      if (wake && pme_en)
        pme_sts <= 1'b1;
      else if (wr_sts && wr_data[0])
        pme_sts <= 1'b0;
    end
  end

  assign link_keep = !((pstate == PS_D3) && !pme_en);
  assign pme_req   = pme_sts & pme_en;
endmodule

// File: rtl/lan_pm_wake_ctrl.sv
module lan_pm_wake_ctrl
  import lpw_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_LEN   = 4
) (
  input  logic              clk_aux,
  input  logic              rst_aux_n,
  input  logic              bus_rst_n,
  input  logic              pwr_good,
  input  logic              link_ok_async,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ignore_bus,
  output logic              reinit,
  output logic              link_mon,
  output logic              link_keep,
  output logic              pme_req
);
  logic    link_s, link_rise, wr_ok;
  pstate_e ps_q;
  logic    pme_en_q, lp_en_q, pme_sts_q;

  lpw_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk_aux),
    .rst_n      (rst_aux_n),
    .link_async (link_ok_async),
    .link_s     (link_s),
    .link_rise  (link_rise)
  );

  lpw_bus_guard #(.PULSE_LEN(PULSE_LEN)) u_guard (
    .clk        (clk_aux),
    .rst_n      (rst_aux_n),
    .bus_rst_n  (bus_rst_n),
    .pwr_good   (pwr_good),
    .ignore_bus (ignore_bus),
    .reinit     (reinit)
  );

  assign wr_ok = wr_en & ~ignore_bus;

  lpw_wake_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk       (clk_aux),
    .rst_n     (rst_aux_n),
    .wr_ok     (wr_ok),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .link_s    (link_s),
    .link_rise (link_rise),
    .pstate    (ps_q),
    .pme_en    (pme_en_q),
    .lp_en     (lp_en_q),
    .pme_sts   (pme_sts_q),
    .link_mon  (link_mon),
    .link_keep (link_keep),
    .pme_req   (pme_req)
  );
endmodule

// File: rtl/lpw_checker.sv
module lpw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst_n,
  input logic       wr_en,
  input logic       ignore_bus,
  input logic       reinit,
  input logic       link_mon,
  input logic       link_s,
  input logic       link_rise,
  input logic [1:0] ps,
  input logic       pme_en,
  input logic       lp_en,
  input logic       pme_sts
);
  p_bus_rst_keeps_ctx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rst_n && !link_rise) |=> ($stable(pme_sts) && $stable(pme_en) && $stable(lp_en)));

  p_ignored_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_bus && wr_en) |=> ($stable(ps) && $stable(pme_en) && $stable(lp_en)));

  p_reinit_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ignore_bus) |=> reinit);

  p_mon_entry_d2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == 2'b10 && lp_en && !link_s && !link_mon) |=> link_mon);

  p_wake_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mon && link_rise && pme_en) |=> (pme_sts && !link_mon));

  p_mon_entry_d3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == 2'b11 && pme_en && lp_en && !link_s && !link_mon) |=> link_mon);

  p_d3_disarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == 2'b11 && !pme_en) |=> !link_mon);

  p_set_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_en |=> !$rose(pme_sts));

  p_exit_on_d0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mon && ps == 2'b00) |=> !link_mon);
endmodule

bind lan_pm_wake_ctrl lpw_checker u_chk (
  .clk        (clk_aux),
  .rst_n      (rst_aux_n),
  .bus_rst_n  (bus_rst_n),
  .wr_en      (wr_en),
  .ignore_bus (ignore_bus),
  .reinit     (reinit),
  .link_mon   (link_mon),
  .link_s     (link_s),
  .link_rise  (link_rise),
  .ps         (ps_q),
  .pme_en     (pme_en_q),
  .lp_en      (lp_en_q),
  .pme_sts    (pme_sts_q)
);

// File: tb/tb_lan_pm_wake_ctrl.sv
module tb_lan_pm_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 4;

  localparam int S_PME = 0, S_MON = 1, S_IGN = 2, S_REI = 3, S_KEEP = 4;

  logic       clk = 1'b0;
  logic       rst_aux_n, bus_rst_n, pwr_good, link_in, wr_en;
  logic [1:0] wr_addr, wr_data;
  logic       ignore_bus, reinit, link_mon, link_keep, pme_req;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int last_c = 0;
  bit done  = 1'b0;

  typedef struct {
    int    due;
    int    sig;
    logic  val;
    string req;
  } exp_t;
  exp_t q[$];

  lan_pm_wake_ctrl #(.PULSE_LEN(PLEN)) dut (
    .clk_aux       (clk),
    .rst_aux_n     (rst_aux_n),
    .bus_rst_n     (bus_rst_n),
    .pwr_good      (pwr_good),
    .link_ok_async (link_in),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .ignore_bus    (ignore_bus),
    .reinit        (reinit),
    .link_mon      (link_mon),
    .link_keep     (link_keep),
    .pme_req       (pme_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic sig_val(int s);
    case (s)
      S_PME:   return pme_req;
      S_MON:   return link_mon;
      S_IGN:   return ignore_bus;
      S_REI:   return reinit;
      default: return link_keep;
    endcase
  endfunction

  function automatic string sig_name(int s);
    case (s)
      S_PME:   return "pme_req";
      S_MON:   return "link_mon";
      S_IGN:   return "ignore_bus";
      S_REI:   return "reinit";
      default: return "link_keep";
    endcase
  endfunction

  function automatic void expect_at(int d, int s, logic v, string req);
    exp_t e;
    e.due = last_c + d; e.sig = s; e.val = v; e.req = req;
    q.push_back(e);
  endfunction

  // monitor: compares every item due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        total++;
        if (sig_val(q[i].sig) !== q[i].val) begin
          bad++;
          $display("FAIL %s cyc=%0d %s actual=%b expected=%b",
                   q[i].req, cyc, sig_name(q[i].sig), sig_val(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic step_in();
    @(negedge clk); #1;
    wr_en = 1'b0;
    last_c = cyc;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    step_in();
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic set_link(input logic v);
    step_in(); link_in = v;
  endtask

  task automatic set_bus(input logic rst_n_v, input logic pg_v);
    step_in(); bus_rst_n = rst_n_v; pwr_good = pg_v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; wr_en = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_aux_n = 1'b0; bus_rst_n = 1'b0; pwr_good = 1'b0; link_in = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    #1 rst_aux_n = 1'b1; last_c = cyc;
    // R10 reset state
    expect_at(1, S_PME, 1'b0, "R10"); expect_at(1, S_MON, 1'b0, "R10");
    expect_at(1, S_REI, 1'b0, "R10"); expect_at(1, S_KEEP, 1'b1, "R10");
    expect_at(1, S_IGN, 1'b1, "R2");
    idle(2);

    // R2: writes while bus in reset are dropped (would enter monitor otherwise)
    wr(2'd1, 2'b11);
    wr(2'd0, 2'b10);
    expect_at(3, S_MON, 1'b0, "R2");
    idle(4);
    set_bus(1'b0, 1'b1);
    expect_at(1, S_IGN, 1'b1, "R2");
    idle(2);

    // R3: release, reinit pulse
    set_bus(1'b1, 1'b1);
    expect_at(1, S_IGN, 1'b0, "R3");
    expect_at(1, S_REI, 1'b1, "R3");
    expect_at(PLEN, S_REI, 1'b1, "R3");
    expect_at(PLEN + 1, S_REI, 1'b0, "R3");
    idle(PLEN + 3);
    set_bus(1'b1, 1'b0);
    expect_at(1, S_IGN, 1'b1, "R2");
    idle(2);
    set_bus(1'b1, 1'b1);
    expect_at(1, S_REI, 1'b1, "R3");
    idle(PLEN + 3);

    // R4 / R11: D2 monitor entry
    wr(2'd1, 2'b11);
    wr(2'd0, 2'b10);
    expect_at(1, S_MON, 1'b0, "R4");
    expect_at(2, S_MON, 1'b1, "R4");
    idle(3);

    // R5: link recovery wakes
    set_link(1'b1);
    expect_at(2, S_MON, 1'b1, "R5"); expect_at(2, S_PME, 1'b0, "R5");
    expect_at(3, S_MON, 1'b0, "R5"); expect_at(3, S_PME, 1'b1, "R5");
    idle(5);

    // R1: bus reset keeps wake context; ignored clear/disable writes
    set_bus(1'b0, 1'b1);
    expect_at(1, S_IGN, 1'b1, "R1"); expect_at(1, S_PME, 1'b1, "R1");
    wr(2'd2, 2'b01);
    expect_at(2, S_PME, 1'b1, "R1");
    wr(2'd1, 2'b00);
    expect_at(2, S_PME, 1'b1, "R1");
    idle(2);
    set_bus(1'b1, 1'b1);
    expect_at(1, S_REI, 1'b1, "R3");
    expect_at(2, S_PME, 1'b1, "R1");
    idle(PLEN + 3);

    // R8: write-one clear
    wr(2'd2, 2'b01);
    expect_at(1, S_PME, 1'b0, "R8");
    idle(2);

    // R8: no set while PME disabled
    set_link(1'b0);
    expect_at(3, S_MON, 1'b1, "R4");
    idle(4);
    wr(2'd1, 2'b10);
    idle(1);
    set_link(1'b1);
    expect_at(3, S_MON, 1'b0, "R8"); expect_at(3, S_PME, 1'b0, "R8");
    idle(4);
    wr(2'd1, 2'b11);
    expect_at(1, S_PME, 1'b0, "R8"); expect_at(3, S_PME, 1'b0, "R8");
    idle(4);

    // R6: D3 armed behaves as D2
    wr(2'd0, 2'b11);
    expect_at(1, S_KEEP, 1'b1, "R6");
    idle(1);
    set_link(1'b0);
    expect_at(3, S_MON, 1'b1, "R6");
    idle(4);
    set_link(1'b1);
    expect_at(3, S_PME, 1'b1, "R6"); expect_at(3, S_MON, 1'b0, "R6");
    idle(4);
    wr(2'd2, 2'b01);
    expect_at(1, S_PME, 1'b0, "R8");
    idle(2);

    // R7: D3 disarmed
    wr(2'd1, 2'b10);
    expect_at(1, S_KEEP, 1'b0, "R7");
    idle(1);
    set_link(1'b0);
    expect_at(3, S_MON, 1'b0, "R7"); expect_at(5, S_MON, 1'b0, "R7");
    idle(6);
    set_link(1'b1);
    expect_at(3, S_PME, 1'b0, "R7");
    idle(4);
    wr(2'd1, 2'b11);
    expect_at(1, S_PME, 1'b0, "R7"); expect_at(1, S_KEEP, 1'b1, "R7");
    idle(2);

    // R9: return to D0 leaves monitor, no later wake
    set_link(1'b0);
    expect_at(3, S_MON, 1'b1, "R6");
    idle(4);
    wr(2'd0, 2'b00);
    expect_at(1, S_MON, 1'b1, "R9"); expect_at(2, S_MON, 1'b0, "R9");
    idle(3);
    set_link(1'b1);
    expect_at(3, S_PME, 1'b0, "R9"); expect_at(3, S_MON, 1'b0, "R9");
    idle(6);

    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule